// File: doc/BRIEF.md
# Access Trace Recorder

The block watches a stream of observed configuration and memory accesses. When recording is on, it stores each one as a fixed five-word record in a buffer whose depth is a parameter. Software turns recording on and off through a one-bit control write. It then drains the buffer through a read port that returns one 32-bit word per read request, starting with the oldest record.

Each record is read out in a fixed order. The first word is an attributes word, followed by the address low half, the address high half, the data low half and the data high half. The attributes word packs the request type, the direction, the space and a one-hot encoding of the access size. Every beat of a burst arrives as its own strobe and is stored as its own record. A full buffer drops new accesses and keeps the older ones. A read with nothing valid left returns all ones.

Top module: `trace_recorder`

## Requirements
- R1: After reset, recording is off (`rec_active_o`=0) and `rd_data_o` reads 0xFFFFFFFF.
- R2: A write with `ctl_we_i`=1 sets the recording state to `ctl_wdata_i` on the next clock, and `rec_active_o` shows that state.
- R3: Each clock with `obs_valid_i`=1 while recording stores one record. Strobes while not recording are dropped and leave the readable contents unchanged.
- R4: Attribute word: bit 0 = `obs_type_i`, bit 1 = `obs_rd_i` (1 read, 0 write), bit 2 = `obs_cfg_i` (1 config, 0 memory), bits 15:3 = 0.
- R5: Attribute bits 31:16 are one-hot, with bit `obs_size_i` set, where `obs_size_i` is log2 of the byte count (8 bytes sets bit 3 of the field).
- R6: The words of a record are read in this order: attributes, address[31:0], address[63:32], data[31:0], data[63:32].
- R7: Records are returned oldest first. When no valid word remains, `rd_data_o` is 0xFFFFFFFF and a read request does not move the pointer.
- R8: Once MAX_RECS records are held, further strobes are dropped, and the stored records stay unchanged.
- R9: A start write (1 while stopped) empties the buffer and resets the read pointer. A stop, or a write of 1 while already recording, keeps the contents.
- R10: Strobes on consecutive clocks (burst beats) each become a separate record.
- R11: `rd_data_o` shows the word at the read pointer. The pointer moves by one word only on a clock with `rd_req_i`=1, and moves to the next record after the fifth word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 1 | Control bit: 1 starts, 0 stops recording |
| obs_valid_i | input | 1 | Observed access strobe, one per beat |
| obs_type_i | input | 1 | Request type |
| obs_rd_i | input | 1 | 1 for read, 0 for write |
| obs_cfg_i | input | 1 | 1 for config, 0 for memory |
| obs_size_i | input | 4 | log2 of access byte count |
| obs_addr_i | input | 64 | Access address |
| obs_data_i | input | 64 | Access data |
| rd_req_i | input | 1 | Read request; consumes the current word |
| rd_data_o | output | 32 | Word at the read pointer, or all ones when empty |
| rec_active_o | output | 1 | Recording state |

## Verification
The hardest situation to reach is the boundary where the buffer fills in the middle of a burst. The beats past capacity must be dropped, while the earlier beats, and a later restart, behave exactly. The bench uses a four-record configuration and drives six back-to-back strobes so that it crosses that limit. It then drains every word and reads past the end. The bench also sweeps all sixteen size codes across several restarted sessions, which exercises each position of the one-hot field together with the clearing on restart.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int unsigned WORDS_PER_REC = 5;
  localparam int unsigned WORD_IDX_W    = 3;

  typedef struct packed {
    logic        req_type;
    logic        is_rd;
    logic        is_cfg;
    logic [3:0]  size_log2;
    logic [63:0] addr;
    logic [63:0] data;
  } trace_rec_t;

  function automatic logic [31:0] fmt_attr(trace_rec_t r);
    logic [15:0] onehot;
    onehot = 16'(1) << r.size_log2;
    return {onehot, 13'b0, r.is_cfg, r.is_rd, r.req_type};
  endfunction
endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl #(
  parameter int unsigned MAX_RECS = 16,
  localparam int unsigned CW = $clog2(MAX_RECS + 1),
  localparam int unsigned IW = (MAX_RECS > 1) ? $clog2(MAX_RECS) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              ctl_we_i,
  input  logic                              ctl_wdata_i,
  input  logic                              obs_valid_i,
  input  logic                              rd_req_i,
  output logic                              rec_en_o,
  output logic                              wr_en_o,
  output logic [IW-1:0]                     wr_idx_o,
  output logic [IW-1:0]                     rd_idx_o,
  output logic [trace_pkg::WORD_IDX_W-1:0]  word_idx_o,
  output logic                              rd_valid_o
);
  import trace_pkg::*;

  logic [CW-1:0]         count_q, rd_rec_q;
  logic [WORD_IDX_W-1:0] word_q;
  logic                  start;

  assign start      = ctl_we_i && ctl_wdata_i && !rec_en_o;
  assign wr_en_o    = rec_en_o && obs_valid_i && (count_q < CW'(MAX_RECS));
  assign rd_valid_o = rd_rec_q < count_q;
  assign wr_idx_o   = IW'(count_q);
  assign rd_idx_o   = IW'(rd_rec_q);
  assign word_idx_o = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_en_o <= 1'b0;
      count_q  <= '0;
      rd_rec_q <= '0;
      word_q   <= '0;
    end else begin
      if (ctl_we_i) rec_en_o <= ctl_wdata_i;
      if (start) begin
        count_q  <= '0;
        rd_rec_q <= '0;
        word_q   <= '0;
      end else begin
        if (wr_en_o) count_q <= count_q + 1'b1;
        if (rd_req_i && rd_valid_o) begin
          if (word_q == WORD_IDX_W'(WORDS_PER_REC - 1)) begin
            word_q   <= '0;
            rd_rec_q <= rd_rec_q + 1'b1;
          end else begin
            word_q <= word_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int unsigned MAX_RECS = 16,
  localparam int unsigned IW = (MAX_RECS > 1) ? $clog2(MAX_RECS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IW-1:0]         wr_idx_i,
  input  trace_pkg::trace_rec_t wr_rec_i,
  input  logic [IW-1:0]         rd_idx_i,
  output trace_pkg::trace_rec_t rd_rec_o
);
  import trace_pkg::*;

  trace_rec_t slot_q [MAX_RECS];

  for (genvar i = 0; i < MAX_RECS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[i] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(i))      slot_q[i] <= wr_rec_i;
    end
  end

  always_comb begin
    rd_rec_o = '0;
    for (int i = 0; i < MAX_RECS; i++)
      if (rd_idx_i == IW'(i)) rd_rec_o = slot_q[i];
  end
endmodule

// File: rtl/trace_word_sel.sv
module trace_word_sel (
  input  trace_pkg::trace_rec_t                 rec_i,
  input  logic [trace_pkg::WORD_IDX_W-1:0]      word_idx_i,
  input  logic                                  valid_i,
  output logic [31:0]                           word_o
);
  import trace_pkg::*;

  always_comb begin
    word_o = '1;
    if (valid_i) begin
      unique case (word_idx_i)
        3'd0:    word_o = fmt_attr(rec_i);
        3'd1:    word_o = rec_i.addr[31:0];
        3'd2:    word_o = rec_i.addr[63:32];
        3'd3:    word_o = rec_i.data[31:0];
        3'd4:    word_o = rec_i.data[63:32];
        default: word_o = '1;
      endcase
    end
  end
endmodule

// File: rtl/trace_recorder.sv
module trace_recorder #(
  parameter int unsigned MAX_RECS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctl_we_i,
  input  logic        ctl_wdata_i,
  input  logic        obs_valid_i,
  input  logic        obs_type_i,
  input  logic        obs_rd_i,
  input  logic        obs_cfg_i,
  input  logic [3:0]  obs_size_i,
  input  logic [63:0] obs_addr_i,
  input  logic [63:0] obs_data_i,
  input  logic        rd_req_i,
  output logic [31:0] rd_data_o,
  output logic        rec_active_o
);
  import trace_pkg::*;

  localparam int unsigned IW = (MAX_RECS > 1) ? $clog2(MAX_RECS) : 1;

  logic                  wr_en, rd_valid;
  logic [IW-1:0]         wr_idx, rd_idx;
  logic [WORD_IDX_W-1:0] word_idx;
  trace_rec_t            wr_rec, rd_rec;

  assign wr_rec = '{req_type: obs_type_i, is_rd: obs_rd_i, is_cfg: obs_cfg_i,
                    size_log2: obs_size_i, addr: obs_addr_i, data: obs_data_i};

  trace_ctrl #(.MAX_RECS(MAX_RECS)) u_ctrl (
    .clk_i, .rst_ni, .ctl_we_i, .ctl_wdata_i, .obs_valid_i, .rd_req_i,
    .rec_en_o(rec_active_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .rd_idx_o(rd_idx), .word_idx_o(word_idx), .rd_valid_o(rd_valid)
  );

  trace_store #(.MAX_RECS(MAX_RECS)) u_store (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_rec_i(wr_rec),
    .rd_idx_i(rd_idx), .rd_rec_o(rd_rec)
  );

  trace_word_sel u_sel (
    .rec_i(rd_rec), .word_idx_i(word_idx), .valid_i(rd_valid), .word_o(rd_data_o)
  );
endmodule

// File: rtl/trace_recorder_chk.sv
module trace_recorder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctl_we_i,
  input logic        ctl_wdata_i,
  input logic        obs_valid_i,
  input logic        rd_req_i,
  input logic [31:0] rd_data_o,
  input logic        rec_active_o,
  input logic [2:0]  word_idx_i
);
  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_wdata_i |=> rec_active_o);

  a_r2_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && !ctl_wdata_i |=> !rec_active_o);

  a_r9_restart_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_wdata_i && !rec_active_o |=> rd_data_o == 32'hFFFF_FFFF);

  a_r4_attr_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_idx_i == 3'd0 && rd_data_o != 32'hFFFF_FFFF |-> rd_data_o[15:3] == 13'd0);

  a_r5_size_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_idx_i == 3'd0 && rd_data_o != 32'hFFFF_FFFF |-> $countones(rd_data_o[31:16]) == 1);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i && !ctl_we_i && !obs_valid_i |=> $stable(rd_data_o) && $stable(word_idx_i));
endmodule

bind trace_recorder trace_recorder_chk u_chk (
  .clk_i, .rst_ni, .ctl_we_i, .ctl_wdata_i, .obs_valid_i, .rd_req_i,
  .rd_data_o, .rec_active_o, .word_idx_i(word_idx)
);

// File: tb/tb_trace_recorder.sv
module tb_trace_recorder;
  localparam int D = 4;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk_i = 0, rst_ni = 0;
  logic ctl_we_i = 0, ctl_wdata_i = 0, obs_valid_i = 0, obs_type_i = 0;
  logic obs_rd_i = 0, obs_cfg_i = 0, rd_req_i = 0;
  logic [3:0]  obs_size_i = 0;
  logic [63:0] obs_addr_i = 0, obs_data_i = 0;
  logic [31:0] rd_data_o;
  logic        rec_active_o;

  int total = 0, bad = 0;
  logic [31:0] ew [D][5];
  int ecnt = 0;
  bit erec = 0;

  always #2.5 clk_i = ~clk_i;

  trace_recorder #(.MAX_RECS(D)) dut (.*);

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic ctl(bit v);
    @(negedge clk_i);
    ctl_we_i = 1; ctl_wdata_i = v;
    @(posedge clk_i); #1;
    ctl_we_i = 0;
    if (v && !erec) ecnt = 0;
    erec = v;
  endtask

  // drive one beat; caller holds obs_valid_i across calls for bursts
  task automatic beat(bit t, bit r, bit c, logic [3:0] s, logic [63:0] a, logic [63:0] d);
    obs_valid_i = 1; obs_type_i = t; obs_rd_i = r; obs_cfg_i = c;
    obs_size_i = s; obs_addr_i = a; obs_data_i = d;
    @(posedge clk_i); #1;
    if (erec && ecnt < D) begin
      ew[ecnt][0] = {16'(1) << s, 13'd0, c, r, t};
      ew[ecnt][1] = a[31:0];
      ew[ecnt][2] = a[63:32];
      ew[ecnt][3] = d[31:0];
      ew[ecnt][4] = d[63:32];
      ecnt++;
    end
  endtask

  task automatic push(bit t, bit r, bit c, logic [3:0] s, logic [63:0] a, logic [63:0] d);
    @(negedge clk_i);
    beat(t, r, c, s, a, d);
    obs_valid_i = 0;
  endtask

  task automatic rd_word(logic [31:0] exp, string tag);
    @(negedge clk_i);
    chk(rd_data_o, exp, tag);
    rd_req_i = 1;
    @(posedge clk_i); #1;
    rd_req_i = 0;
  endtask

  task automatic drain(string tag);
    for (int r = 0; r < ecnt; r++)
      for (int w = 0; w < 5; w++) rd_word(ew[r][w], tag);
    rd_word(ONES, "R7 empty after drain");
    rd_word(ONES, "R7 empty no advance");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i); #1;
    rst_ni = 1;
    @(negedge clk_i);
    chk({31'd0, rec_active_o}, 0, "R1 rec off");
    chk(rd_data_o, ONES, "R1 empty read");

    // strobe while stopped is dropped
    push(1, 1, 1, 3, 64'h1, 64'h2);
    chk(rd_data_o, ONES, "R3 dropped when off");
    ctl(1);
    @(negedge clk_i);
    chk({31'd0, rec_active_o}, 1, "R2 started");
    chk(rd_data_o, ONES, "R9 empty after start");

    push(0, 1, 0, 3, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00);
    push(1, 0, 1, 0, 64'hDEAD_BEEF_0000_0010, 64'h0123_4567_89AB_CDEF);
    push(1, 1, 1, 15, 64'hFFFF_0000_FFFF_0004, 64'h8000_0000_0000_0001);
    // R11: idle cycles keep the same word visible
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(rd_data_o, ew[0][0], "R11 hold without read");
    // R9: write 1 while recording keeps contents
    ctl(1);
    rd_word(ew[0][0], "R9 rewrite 1 keeps");
    rd_word(ew[0][1], "R6 addr lo");
    rd_word(ew[0][2], "R6 addr hi");
    rd_word(ew[0][3], "R6 data lo");
    rd_word(ew[0][4], "R6 data hi");
    for (int r = 1; r < ecnt; r++)
      for (int w = 0; w < 5; w++) rd_word(ew[r][w], "R4 R7 oldest first");
    rd_word(ONES, "R7 empty");
    rd_word(ONES, "R7 no advance");

    // restart, then burst past capacity
    ctl(0);
    @(negedge clk_i);
    chk({31'd0, rec_active_o}, 0, "R2 stopped");
    ctl(1);
    chk(rd_data_o, ONES, "R9 restart clears");
    @(negedge clk_i);
    for (int b = 0; b < 6; b++)
      beat(b[0], b[1], b[2], 4'(b + 2), {32'hB000_0000 + b, 32'(b * 7)},
           {32'(b * 3), 32'hC0DE_0000 + b});
    obs_valid_i = 0;
    chk(32'(ecnt), D, "R8 model full");
    drain("R8 R10 burst kept first beats");

    // stop keeps contents readable, strobes dropped while stopped
    ctl(1);
    ctl(0); ctl(1);
    push(0, 0, 0, 1, 64'h10, 64'h20);
    ctl(0);
    push(1, 1, 1, 2, 64'h30, 64'h40);
    drain("R3 R9 stop keeps contents");

    // size sweep over all 16 codes, four records per session
    for (int sess = 0; sess < 4; sess++) begin
      ctl(0); ctl(1);
      for (int k = 0; k < 4; k++)
        push(k[0], k[1], sess[0], 4'(sess * 4 + k),
             {32'hA000_0000 + 32'(sess), 32'(32'h1000 * sess + k)},
             {32'(sess * 16 + k), 32'h5A5A_0000 ^ 32'(k)});
      drain("R5 size sweep");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule